// File: doc/BRIEF.md
# Streaming COBS Frame Encoder

The encoder takes raw byte frames on an 8-bit valid/ready stream and emits them in Consistent Overhead Byte Stuffing form. In that form the output has no zero byte except one 0x00 delimiter per frame. The input marks the final byte of a frame with a last flag. On the output, the delimiter is the only beat that carries the last flag. A receiver can therefore resynchronise on any zero byte.

Each output group starts with a code byte. The code byte tells the receiver how many data bytes follow, and whether a zero is implied after them. The code byte must go out before its data bytes, so the encoder collects non-zero bytes in a segment buffer of 254 entries. When a group closes, the encoder stops taking input and sends the code byte, then the buffered bytes, then any closing code and the delimiter. After that it accepts input again. Backpressure is handled on both sides: a stalled output beat keeps its value until it is accepted.

Top module: `cobs_stream_encoder`

## Requirements
- R1: A group's code byte equals one plus the number of non-zero bytes in the group. Frame 11 22 33 (last on 33) encodes to 04 11 22 33 00.
- R2: A zero input byte closes the current group. The code byte and the buffered bytes are sent, and the zero byte itself never appears in the output.
- R3: As soon as 254 non-zero bytes are buffered, the encoder sends that group with code 0xFF and no implied zero. The next group starts counting at code 1.
- R4: A frame that ends exactly on a 0xFF group gets no further code byte. Its output is that group followed directly by the delimiter.
- R5: A frame whose last byte is zero ends with an extra group of code 0x01 before the delimiter.
- R6: Every encoded frame is followed by exactly one 0x00 byte. This byte has out_last=1, and out_last is 0 on all other beats.
- R7: No output beat other than the delimiter carries the value 0x00.
- R8: in_ready is low whenever out_valid is high. The encoder accepts no input while a group, code or delimiter is being sent.
- R9: The output order is the code byte first, then the segment bytes oldest first. While out_ready is low, out_valid, out_data and out_last hold their values, so no byte is lost or repeated under any output backpressure.
- R10: After a synchronous active-high reset, out_valid is 0, in_ready is 1 and the segment is empty with code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Raw frame byte |
| in_valid | input | 1 | in_data is valid |
| in_last | input | 1 | Final byte of the frame |
| in_ready | output | 1 | Encoder accepts a byte |
| out_data | output | 8 | Encoded byte |
| out_valid | output | 1 | out_data is valid |
| out_last | output | 1 | Beat is the frame delimiter |
| out_ready | input | 1 | Downstream accepts the beat |

## Verification
Every frame of one to six bytes is tried, with each possible placement of zeros among the bytes. This shows whether a zero in the first, middle or last position gives the right code values, the dropped zero, and the trailing 0x01 group. Long runs of 253, 254, 255 and 508 non-zero bytes, and a run of 254 followed by a zero, separate the just-below-full case, the exact 0xFF ending with no extra code, and a fresh group after 0xFF. The whole set runs once with free-flowing ports and once with a fixed pattern of output stalls and input gaps. Each output byte is compared in order with an arithmetic model, which exposes any byte dropped or repeated under backpressure.

// File: rtl/cobs_stream_encoder.sv
module cobs_stream_encoder (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  output logic       out_last,
  input  logic       out_ready
);
  localparam int GROUP_MAX = 254;
  localparam logic [7:0] LAST_SLOT = 8'(GROUP_MAX - 1);

  typedef enum logic [1:0] {S_TAKE, S_CODE, S_DATA, S_DELIM} state_t;

  state_t     state;
  logic [7:0] seg [GROUP_MAX];
  logic [7:0] cnt;
  logic [7:0] rd;
  logic       open;
  logic       fin;

  wire take = in_valid && in_ready;
  wire give = out_valid && out_ready;
  wire group_done = give && ((state == S_CODE && cnt == 8'd0) ||
                             (state == S_DATA && rd == cnt - 8'd1));

  assign in_ready  = (state == S_TAKE);
  assign out_valid = (state != S_TAKE);
  assign out_last  = (state == S_DELIM);
  assign out_data  = (state == S_CODE) ? cnt + 8'd1 :
                     (state == S_DATA) ? seg[rd] : 8'd0;

  always_ff @(posedge clk)
    if (take && in_data != 8'd0) seg[cnt] <= in_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_TAKE;
      cnt   <= 8'd0;
      rd    <= 8'd0;
      open  <= 1'b1;
      fin   <= 1'b0;
    end else begin
      case (state)
        S_TAKE: if (take) begin
          fin <= in_last;
          if (in_data == 8'd0) begin
            open  <= 1'b1;
            state <= S_CODE;
          end else begin
            cnt <= cnt + 8'd1;
            if (cnt == LAST_SLOT || in_last) begin
              open  <= 1'b0;
              state <= S_CODE;
            end
          end
        end
        S_CODE: if (give) begin
          rd <= 8'd0;
          if (cnt != 8'd0) state <= S_DATA;
        end
        S_DATA: if (give) rd <= rd + 8'd1;
        S_DELIM: if (give) begin
          state <= S_TAKE;
          open  <= 1'b1;
          fin   <= 1'b0;
        end
        default: state <= S_TAKE;
      endcase
      if (group_done) begin
        cnt <= 8'd0;
        if (!fin) state <= S_TAKE;
        else if (open) begin
          open  <= 1'b0;
          state <= S_CODE;
        end else state <= S_DELIM;
      end
    end
  end
endmodule

// File: rtl/cobs_stream_encoder_chk.sv
module cobs_stream_encoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_last,
  input logic       out_ready
);
  a_r7_no_inner_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |-> (out_data != 8'd0));

  a_r6_delim_is_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> (out_data == 8'd0));

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  a_r8_no_take_while_sending: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (in_ready && !out_valid));
endmodule

bind cobs_stream_encoder cobs_stream_encoder_chk u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_data(out_data),
  .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready)
);

// File: tb/cobs_stream_encoder_tb.sv
module cobs_stream_encoder_tb;
  typedef logic [7:0] bq_t[$];

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = 8'd0;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic [7:0] out_data;
  logic       out_valid;
  logic       out_last;
  logic       out_ready = 1'b0;

  always #5 clk = ~clk;

  cobs_stream_encoder u_dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready)
  );

  int checks = 0;
  int fails = 0;
  int overlap = 0;
  int cyc = 0;
  bit bp = 1'b0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;
  logic [8:0] exp_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_exp(input logic [7:0] b, input bit last, input string tag);
    exp_q.push_back({last, b});
    tag_q.push_back(tag);
  endtask

  task automatic model(input bq_t f, input string tag);
    int code = 1;
    bit nd = 1'b1;
    bq_t seg;
    foreach (f[i]) begin
      if (f[i] == 8'd0) begin
        push_exp(8'(code), 1'b0, tag);
        foreach (seg[k]) push_exp(seg[k], 1'b0, tag);
        seg.delete(); code = 1; nd = 1'b1;
      end else begin
        seg.push_back(f[i]); code++; nd = 1'b1;
        if (code == 255) begin
          push_exp(8'hFF, 1'b0, tag);
          foreach (seg[k]) push_exp(seg[k], 1'b0, tag);
          seg.delete(); code = 1; nd = 1'b0;
        end
      end
    end
    if (nd) begin
      push_exp(8'(code), 1'b0, tag);
      foreach (seg[k]) push_exp(seg[k], 1'b0, tag);
    end
    push_exp(8'h00, 1'b1, "R6");
  endtask

  task automatic send_frame(input bq_t f, input string tag);
    model(f, tag);
    for (int i = 0; i < f.size(); i++) begin
      if (bp && (i % 4 == 3)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = f[i];
      in_last  = (i == f.size() - 1);
      begin
        bit took;
        do begin
          took = in_ready;
          @(negedge clk);
        end while (!took);
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic run_nz(input int n, input bit zero_tail, input string tag);
    bq_t f;
    for (int i = 0; i < n; i++) f.push_back(8'((i % 255) + 1));
    if (zero_tail) f.push_back(8'd0);
    send_frame(f, tag);
  endtask

  task automatic run_all();
    for (int len = 1; len <= 6; len++)
      for (int m = 0; m < (1 << len); m++) begin
        bq_t f;
        string tag;
        for (int i = 0; i < len; i++)
          f.push_back(m[i] ? 8'd0 : 8'(len * 16 + i + 1));
        if (m[len-1]) tag = "R5";
        else if (m != 0) tag = "R2";
        else tag = "R1";
        send_frame(f, tag);
      end
    run_nz(253, 1'b0, "R1");
    run_nz(254, 1'b0, "R4");
    run_nz(255, 1'b0, "R3");
    run_nz(254, 1'b1, "R3");
    run_nz(508, 1'b0, "R4");
    begin
      bq_t f;
      for (int i = 0; i < 100; i++) f.push_back(8'(i + 1));
      f.push_back(8'd0);
      for (int i = 0; i < 200; i++) f.push_back(8'(i + 7));
      send_frame(f, "R2");
    end
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      out_ready = bp ? ((cyc % 5 != 1) && (cyc % 7 != 3)) : 1'b1;
      if (in_ready && out_valid) overlap++;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", {out_last, out_data}, 0);
        end else begin
          logic [8:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data == e[7:0], t, out_data, e[7:0]);
          check(out_last == e[8], "R6", out_last, e[8]);
          if (!out_last) check(out_data != 8'd0, "R7", out_data, 1);
        end
      end
    end
  end

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R10", in_ready, 1);
    check(out_valid == 1'b0, "R10", out_valid, 0);
    mon_on = 1'b1;
    bp = 1'b0;
    run_all();
    bp = 1'b1;
    run_all();
    check(overlap == 0, "R8", overlap, 0);
    repeat (5) @(negedge clk);
    finish_up();
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "R9 watchdog", exp_q.size(), 0);
    finish_up();
  end
endmodule